// File: doc/BRIEF.md
# Bidirectional Two-Node Mailbox Link

The block joins a lower-numbered node and a higher-numbered node with a pair of one-message mailboxes. The upstream mailbox carries a message from the lower node to the higher node, and the downstream mailbox carries a message the other way. Each message is a fixed number of words, four 64-bit words by default. The link does not queue messages. Each direction holds at most one message, and a four-state ownership handshake controls who may touch that message.

A sender claims its mailbox, writes the words in order, and commits. The receiver then reads the words in the same order and acknowledges. The state is released to idle on the next cycle. If a side drives a control that the current state does not permit, the command is dropped and that side sees an error pulse one cycle long. The two directions share no state, so both can transfer at the same time.

Top module: `mailbox_link`

## Requirements
- R1: After reset both direction states read 0 (idle), both error outputs are low and both read-data outputs are zero.
- R2: State codes are 0 idle, 1 filling, 2 full and 3 consumed. A start command in idle moves the state to 1 on the next cycle.
- R3: In state 1 each write stores one word at the next position, from 0 up to 3. A commit made after the fourth write moves the state to 2 on the next cycle. A whole message therefore takes six command cycles: start, four writes and commit.
- R4: In state 2 each read command returns the next stored word in write order on the read-data output in the same cycle.
- R5: An acknowledge after all four reads moves the state to 3. The state returns to 0 one cycle later without any further command. An acknowledge before all four reads is refused with an error and the state stays 2.
- R6: A start command when the state is not 0 raises that side's error output for the next cycle and changes no state.
- R7: A commit with fewer than four words written raises the error and the state stays 1.
- R8: A read command outside state 2, or after all four words have been read, returns zero and raises the error.
- R9: A write outside state 1, or a fifth write, raises the error and leaves the stored message unchanged.
- R10: Upstream is written only from the lower-side ports and read only at the higher-side ports. Downstream is the mirror image. A side's error output combines its sender errors and its receiver errors.
- R11: Transfers in the two directions can overlap cycle by cycle and do not affect each other's data or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lo_wr_start_i | input | 1 | Lower side claims the upstream mailbox |
| lo_wr_en_i | input | 1 | Lower side writes one upstream word |
| lo_wr_data_i | input | WORD_W | Upstream write word |
| lo_commit_i | input | 1 | Lower side marks upstream message complete |
| lo_rd_en_i | input | 1 | Lower side reads one downstream word |
| lo_rd_ack_i | input | 1 | Lower side acknowledges downstream message |
| lo_rd_data_o | output | WORD_W | Downstream word read (zero when not valid) |
| lo_err_o | output | 1 | Lower side protocol error pulse |
| hi_wr_start_i | input | 1 | Higher side claims the downstream mailbox |
| hi_wr_en_i | input | 1 | Higher side writes one downstream word |
| hi_wr_data_i | input | WORD_W | Downstream write word |
| hi_commit_i | input | 1 | Higher side marks downstream message complete |
| hi_rd_en_i | input | 1 | Higher side reads one upstream word |
| hi_rd_ack_i | input | 1 | Higher side acknowledges upstream message |
| hi_rd_data_o | output | WORD_W | Upstream word read (zero when not valid) |
| hi_err_o | output | 1 | Higher side protocol error pulse |
| up_state_o | output | 2 | Upstream handshake state |
| dn_state_o | output | 2 | Downstream handshake state |

## Verification
The assertions check four things on every cycle: the allowed state transitions, the automatic release from consumed to idle, zero read data outside the full state, and the error pulse that follows a refused start. Word order, the refusal of early commits and early acknowledges, the contents left unchanged after an illegal write, and the independence of overlapping transfers in the two directions are shown only by the bench scenarios. In those scenarios a behavioural model is compared with the ports on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    MB_IDLE = 2'd0,
    MB_FILL = 2'd1,
    MB_FULL = 2'd2,
    MB_DONE = 2'd3
  } mb_state_e;
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int WORD_W  = 64,
  parameter int N_WORDS = 4,
  localparam int AW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[w] <= '0;
      else if (we_i && waddr_i == AW'(w))       mem_q[w] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mbx_dir.sv
module mbx_dir
  import mbx_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int N_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              rd_en_i,
  input  logic              ack_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              tx_err_o,
  output logic              rx_err_o,
  output logic [1:0]        state_o
);
  localparam int AW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int CW = $clog2(N_WORDS + 1);
  localparam logic [CW-1:0] LAST = CW'(N_WORDS);

  mb_state_e       state_q, state_d;
  logic [CW-1:0]   wr_idx_q, rd_idx_q;
  logic            tx_bad, rx_bad, do_write, rd_ok, claim, seal;
  logic [WORD_W-1:0] rdata;

  // sender precedence: start, then commit, then write
  always_comb begin
    state_d  = state_q;
    tx_bad   = 1'b0;
    rx_bad   = 1'b0;
    do_write = 1'b0;
    rd_ok    = 1'b0;
    claim    = 1'b0;
    seal     = 1'b0;
    if (start_i) begin
      if (state_q == MB_IDLE) begin state_d = MB_FILL; claim = 1'b1; end
      else tx_bad = 1'b1;
    end else if (commit_i) begin
      if (state_q == MB_FILL && wr_idx_q == LAST) begin state_d = MB_FULL; seal = 1'b1; end
      else tx_bad = 1'b1;
    end else if (wr_en_i) begin
      if (state_q == MB_FILL && wr_idx_q != LAST) do_write = 1'b1;
      else tx_bad = 1'b1;
    end
    if (ack_i) begin
      if (state_q == MB_FULL && rd_idx_q == LAST) state_d = MB_DONE;
      else rx_bad = 1'b1;
    end else if (rd_en_i) begin
      if (state_q == MB_FULL && rd_idx_q != LAST) rd_ok = 1'b1;
      else rx_bad = 1'b1;
    end
    if (state_q == MB_DONE) state_d = MB_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= MB_IDLE;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      tx_err_o <= 1'b0;
      rx_err_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      tx_err_o <= tx_bad;
      rx_err_o <= rx_bad;
      if (claim)         wr_idx_q <= '0;
      else if (do_write) wr_idx_q <= wr_idx_q + 1'b1;
      if (seal)          rd_idx_q <= '0;
      else if (rd_ok)    rd_idx_q <= rd_idx_q + 1'b1;
    end
  end

  mbx_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (do_write),
    .waddr_i (wr_idx_q[AW-1:0]),
    .wdata_i (wr_data_i),
    .raddr_i (rd_idx_q[AW-1:0]),
    .rdata_o (rdata)
  );

  assign rd_data_o = rd_ok ? rdata : '0;
  assign state_o   = state_q;
endmodule

// File: rtl/mailbox_link.sv
module mailbox_link #(
  parameter int WORD_W  = 64,
  parameter int N_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_wr_start_i,
  input  logic              lo_wr_en_i,
  input  logic [WORD_W-1:0] lo_wr_data_i,
  input  logic              lo_commit_i,
  input  logic              lo_rd_en_i,
  input  logic              lo_rd_ack_i,
  output logic [WORD_W-1:0] lo_rd_data_o,
  output logic              lo_err_o,
  input  logic              hi_wr_start_i,
  input  logic              hi_wr_en_i,
  input  logic [WORD_W-1:0] hi_wr_data_i,
  input  logic              hi_commit_i,
  input  logic              hi_rd_en_i,
  input  logic              hi_rd_ack_i,
  output logic [WORD_W-1:0] hi_rd_data_o,
  output logic              hi_err_o,
  output logic [1:0]        up_state_o,
  output logic [1:0]        dn_state_o
);
  logic up_tx_err, up_rx_err, dn_tx_err, dn_rx_err;

  mbx_dir #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_up (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (lo_wr_start_i),
    .wr_en_i   (lo_wr_en_i),
    .wr_data_i (lo_wr_data_i),
    .commit_i  (lo_commit_i),
    .rd_en_i   (hi_rd_en_i),
    .ack_i     (hi_rd_ack_i),
    .rd_data_o (hi_rd_data_o),
    .tx_err_o  (up_tx_err),
    .rx_err_o  (up_rx_err),
    .state_o   (up_state_o)
  );

  mbx_dir #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_dn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (hi_wr_start_i),
    .wr_en_i   (hi_wr_en_i),
    .wr_data_i (hi_wr_data_i),
    .commit_i  (hi_commit_i),
    .rd_en_i   (lo_rd_en_i),
    .ack_i     (lo_rd_ack_i),
    .rd_data_o (lo_rd_data_o),
    .tx_err_o  (dn_tx_err),
    .rx_err_o  (dn_rx_err),
    .state_o   (dn_state_o)
  );

  assign lo_err_o = up_tx_err | dn_rx_err;
  assign hi_err_o = dn_tx_err | up_rx_err;
endmodule

// File: rtl/mbx_link_chk.sv
module mbx_link_chk #(
  parameter int WORD_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lo_wr_start_i,
  input logic              hi_wr_start_i,
  input logic              lo_err_o,
  input logic              hi_err_o,
  input logic [WORD_W-1:0] lo_rd_data_o,
  input logic [WORD_W-1:0] hi_rd_data_o,
  input logic [1:0]        up_state_o,
  input logic [1:0]        dn_state_o
);
  // R5
  up_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_state_o == 2'd3 |=> up_state_o == 2'd0);
  // R5
  dn_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_state_o == 2'd3 |=> dn_state_o == 2'd0);
  // R2
  up_idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_state_o == 2'd0 |=> up_state_o inside {2'd0, 2'd1});
  // R2
  dn_idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_state_o == 2'd0 |=> dn_state_o inside {2'd0, 2'd1});
  // R3
  up_full_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_state_o != 2'd1 && up_state_o != 2'd2) |=> up_state_o != 2'd2);
  // R3
  dn_full_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_state_o != 2'd1 && dn_state_o != 2'd2) |=> dn_state_o != 2'd2);
  // R8
  hi_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_state_o != 2'd2 |-> hi_rd_data_o == '0);
  // R8
  lo_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_state_o != 2'd2 |-> lo_rd_data_o == '0);
  // R6
  lo_start_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wr_start_i && up_state_o != 2'd0) |=> lo_err_o);
  // R6
  hi_start_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr_start_i && dn_state_o != 2'd0) |=> hi_err_o);
endmodule

bind mailbox_link mbx_link_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lo_wr_start_i (lo_wr_start_i),
  .hi_wr_start_i (hi_wr_start_i),
  .lo_err_o      (lo_err_o),
  .hi_err_o      (hi_err_o),
  .lo_rd_data_o  (lo_rd_data_o),
  .hi_rd_data_o  (hi_rd_data_o),
  .up_state_o    (up_state_o),
  .dn_state_o    (dn_state_o)
);

// File: tb/tb_mailbox_link.sv
module tb_mailbox_link;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic lo_start = 0, lo_we = 0, lo_commit = 0, lo_re = 0, lo_ack = 0;
  logic hi_start = 0, hi_we = 0, hi_commit = 0, hi_re = 0, hi_ack = 0;
  logic [63:0] lo_wd = '0, hi_wd = '0;
  logic [63:0] lo_rd, hi_rd;
  logic lo_err, hi_err;
  logic [1:0] up_st, dn_st;

  mailbox_link dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lo_wr_start_i(lo_start), .lo_wr_en_i(lo_we), .lo_wr_data_i(lo_wd),
    .lo_commit_i(lo_commit), .lo_rd_en_i(lo_re), .lo_rd_ack_i(lo_ack),
    .lo_rd_data_o(lo_rd), .lo_err_o(lo_err),
    .hi_wr_start_i(hi_start), .hi_wr_en_i(hi_we), .hi_wr_data_i(hi_wd),
    .hi_commit_i(hi_commit), .hi_rd_en_i(hi_re), .hi_rd_ack_i(hi_ack),
    .hi_rd_data_o(hi_rd), .hi_err_o(hi_err),
    .up_state_o(up_st), .dn_state_o(dn_st)
  );

  int total = 0, bad = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural model, index 0 = upstream, 1 = downstream
  int m_st[2], m_wi[2], m_ri[2];
  bit m_te[2], m_re[2];
  logic [63:0] m_buf[2][4];

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        m_st[d] = 0; m_wi[d] = 0; m_ri[d] = 0; m_te[d] = 0; m_re[d] = 0;
        for (int w = 0; w < 4; w++) m_buf[d][w] = '0;
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        bit s_start, s_we, s_commit, r_re, r_ack, te, re;
        logic [63:0] wd;
        int nst;
        s_start  = d == 0 ? lo_start  : hi_start;
        s_we     = d == 0 ? lo_we     : hi_we;
        s_commit = d == 0 ? lo_commit : hi_commit;
        wd       = d == 0 ? lo_wd     : hi_wd;
        r_re     = d == 0 ? hi_re     : lo_re;
        r_ack    = d == 0 ? hi_ack    : lo_ack;
        nst = m_st[d]; te = 0; re = 0;
        if (s_start) begin
          if (m_st[d] == 0) begin nst = 1; m_wi[d] = 0; end else te = 1;
        end else if (s_commit) begin
          if (m_st[d] == 1 && m_wi[d] == 4) begin nst = 2; m_ri[d] = 0; end else te = 1;
        end else if (s_we) begin
          if (m_st[d] == 1 && m_wi[d] < 4) begin m_buf[d][m_wi[d]] = wd; m_wi[d]++; end
          else te = 1;
        end
        if (r_ack) begin
          if (m_st[d] == 2 && m_ri[d] == 4) nst = 3; else re = 1;
        end else if (r_re) begin
          if (m_st[d] == 2 && m_ri[d] < 4) m_ri[d]++; else re = 1;
        end
        if (m_st[d] == 3) nst = 0;
        m_st[d] = nst; m_te[d] = te; m_re[d] = re;
      end
    end
  end

  function automatic logic [63:0] exp_rd(int d, bit rre, bit rack);
    if (!rack && rre && m_st[d] == 2 && m_ri[d] < 4) return m_buf[d][m_ri[d]];
    return '0;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      chk({tag, " up_state"}, 64'(up_st), 64'(m_st[0]));
      chk({tag, " dn_state"}, 64'(dn_st), 64'(m_st[1]));
      chk({tag, " lo_err"}, 64'(lo_err), 64'(m_te[0] | m_re[1]));
      chk({tag, " hi_err"}, 64'(hi_err), 64'(m_te[1] | m_re[0]));
      chk({tag, " hi_rd"}, hi_rd, exp_rd(0, hi_re, hi_ack));
      chk({tag, " lo_rd"}, lo_rd, exp_rd(1, lo_re, lo_ack));
    end
  end

  task automatic nxt();
    @(negedge clk);
    lo_start = 0; lo_we = 0; lo_commit = 0; lo_re = 0; lo_ack = 0;
    hi_start = 0; hi_we = 0; hi_commit = 0; hi_re = 0; hi_ack = 0;
  endtask

  task automatic lo_send(logic [63:0] base);
    nxt(); lo_start = 1;
    for (int i = 0; i < 4; i++) begin nxt(); lo_we = 1; lo_wd = base + 64'(i); end
    nxt(); lo_commit = 1;
  endtask

  task automatic hi_recv(logic [63:0] base);
    for (int i = 0; i < 4; i++) begin
      nxt(); hi_re = 1; #1;
      chk("R4 hi word order", hi_rd, base + 64'(i));
    end
    nxt(); hi_ack = 1;
  endtask

  initial begin
    #3;
    // R1 reset values
    #1;
    chk("R1 up_state", 64'(up_st), 0);
    chk("R1 dn_state", 64'(dn_st), 0);
    chk("R1 err", 64'({lo_err, hi_err}), 0);
    chk("R1 rd", lo_rd | hi_rd, 0);
    @(negedge clk); rst_n = 1;

    // R2 R3 R10 upstream message written from lower side
    tag = "R3";
    lo_send(64'hA000_0000_0000_0010);
    nxt(); #1;
    chk("R3 full after six cycles", 64'(up_st), 2);
    chk("R10 dn untouched", 64'(dn_st), 0);

    // R9 fifth write while full is refused
    tag = "R9";
    lo_we = 1; lo_wd = 64'hDEAD;
    nxt(); #1; chk("R9 err", 64'(lo_err), 1);

    // R4 R5 read out at higher side and release
    tag = "R4";
    hi_recv(64'hA000_0000_0000_0010);
    nxt(); #1; chk("R5 consumed", 64'(up_st), 3);
    tag = "R5";
    nxt(); #1; chk("R5 auto idle", 64'(up_st), 0);

    // R8 read in idle
    tag = "R8";
    hi_re = 1; #1; chk("R8 rd zero", hi_rd, 0);
    nxt(); #1; chk("R8 err", 64'(hi_err), 1);

    // R6 second start refused
    tag = "R6";
    lo_start = 1; nxt(); lo_start = 1;
    nxt(); #1; chk("R6 err", 64'(lo_err), 1); chk("R6 state", 64'(up_st), 1);

    // R7 early commit
    tag = "R7";
    lo_we = 1; lo_wd = 64'h11;
    nxt(); lo_commit = 1;
    nxt(); #1; chk("R7 err", 64'(lo_err), 1); chk("R7 still filling", 64'(up_st), 1);
    for (int i = 1; i < 4; i++) begin nxt(); lo_we = 1; lo_wd = 64'h11 + 64'(i); end
    nxt(); lo_commit = 1;

    // R5 early acknowledge, R8 read past end
    tag = "R5";
    nxt(); hi_ack = 1;
    nxt(); #1; chk("R5 early ack err", 64'(hi_err), 1); chk("R5 stays full", 64'(up_st), 2);
    hi_recv(64'h11);
    nxt(); tag = "R8"; hi_re = 1; #1; chk("R8 past end zero", hi_rd, 0);
    nxt(); hi_ack = 1;
    nxt(); nxt();

    // R9 write in idle ignored, R11 overlapping both directions
    tag = "R9";
    hi_we = 1; hi_wd = 64'hBAD;
    nxt(); #1; chk("R9 idle write err", 64'(hi_err), 1);
    tag = "R11";
    nxt(); lo_start = 1; hi_start = 1;
    for (int i = 0; i < 4; i++) begin
      nxt(); lo_we = 1; lo_wd = 64'h500 + 64'(i); hi_we = 1; hi_wd = 64'h900 + 64'(i);
    end
    nxt(); lo_commit = 1; hi_commit = 1;
    for (int i = 0; i < 4; i++) begin
      nxt(); lo_re = 1; hi_re = 1; #1;
      chk("R11 lo sees downstream", lo_rd, 64'h900 + 64'(i));
      chk("R11 hi sees upstream", hi_rd, 64'h500 + 64'(i));
    end
    nxt(); lo_ack = 1; hi_ack = 1;
    nxt(); nxt(); #1;
    chk("R11 both idle", 64'({up_st, dn_st}), 0);
    nxt();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule